// File: doc/BRIEF.md
# Registered bidirectional port with parity and status flags

This block moves bytes between two sides, called A and B, through two independent holding registers. The forward path latches A data and presents it on the B side with a generated parity bit. The return path latches B data together with an incoming parity bit and presents it on the A side with an active-low parity error indication. Each path has its own load strobe, active-low load enable, status flag and active-low output enable. A consumer reads a port by pulling its output enable low. When it lets the enable rise again, that rise acknowledges the transfer and clears the matching flag.

All strobes and output enables are sampled in one system clock domain, and their rising edges are detected there. The tri-state pins are modelled as a data output paired with a drive-enable output. A synchronous reset empties both registers, clears the parity register and clears both flags.

Top module: `regxcvr_parity`

## Requirements
- R1: On a rising edge of `fwd_stb` while `fwd_ld_n` is low, the forward register captures `a_in`; the new value is visible at `b_out` one clock after the clock that samples the strobe high.
- R2: A rising edge of `fwd_stb` while `fwd_ld_n` is high leaves the forward register unchanged, and the same rule applies to the return register with `ret_stb` and `ret_ld_n`.
- R3: On a rising edge of `ret_stb` while `ret_ld_n` is low, the return register captures `b_in` and the parity register captures `par_in`, both on the same edge.
- R4: Each flag (`fwd_flag`, `ret_flag`) goes to 1 when its register loads.
- R5: A flag goes to 0 after a low-to-high transition of its side's output enable (`fwd_oe_n` for the forward flag, `ret_oe_n` for the return flag). Without a load or such a transition, the flag holds its value.
- R6: If a load and a flag-clearing enable rise fall in the same clock, the flag ends up 1.
- R7: `b_oe` equals the inverse of `fwd_oe_n`, and it drives both `b_out` and `par_out`. `a_oe` equals the inverse of `ret_oe_n`.
- R8: `par_out` is 1 when the forward register holds an even count of ones, zero ones included. It is 0 when the count is odd.
- R9: `err_n` is 0 when the return register and the parity register together hold an even count of ones, and 1 when the count is odd. It is forced to 1 while `ret_oe_n` is high.
- R10: A synchronous reset clears both registers, the parity register and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| a_in | input | W | A-side data into the forward register |
| fwd_stb | input | 1 | forward load strobe (rising edge) |
| fwd_ld_n | input | 1 | forward load enable, active low |
| fwd_oe_n | input | 1 | B-side output enable, active low; its rise clears fwd_flag |
| b_out | output | W | forward register contents toward B |
| b_oe | output | 1 | drive enable for b_out and par_out |
| par_out | output | 1 | generated parity bit |
| fwd_flag | output | 1 | forward register holds fresh data |
| b_in | input | W | B-side data into the return register |
| par_in | input | 1 | incoming parity bit |
| ret_stb | input | 1 | return load strobe (rising edge) |
| ret_ld_n | input | 1 | return load enable, active low |
| ret_oe_n | input | 1 | A-side output enable, active low; its rise clears ret_flag |
| a_out | output | W | return register contents toward A |
| a_oe | output | 1 | drive enable for a_out |
| ret_flag | output | 1 | return register holds fresh data |
| err_n | output | 1 | parity error, active low |

## Verification
The assertions assume that strobes and enables are synchronous to `clk` and hold each level for at least one clock, so that every edge of interest appears as a one-cycle level change between samples. The bench drives every input away from the active clock edge and changes each control at most once per cycle, so this assumption holds. Random stimulus walks the strobes, enables and data freely within these limits. Directed steps cover a load that is blocked by its enable, all-zero and all-one bytes, and a load that falls in the same cycle as a flag clear.

// File: rtl/regxcvr_parity.sv
module regxcvr_parity #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic         fwd_stb,
  input  logic         fwd_ld_n,
  input  logic         fwd_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic         par_out,
  output logic         fwd_flag,
  input  logic [W-1:0] b_in,
  input  logic         par_in,
  input  logic         ret_stb,
  input  logic         ret_ld_n,
  input  logic         ret_oe_n,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic         ret_flag,
  output logic         err_n
);

  logic [W-1:0] fwd_q, ret_q;
  logic         par_q;
  logic         fstb_d, rstb_d, foe_d, roe_d;

  wire fwd_load = fwd_stb & ~fstb_d & ~fwd_ld_n;
  wire ret_load = ret_stb & ~rstb_d & ~ret_ld_n;
  wire fwd_ack  = fwd_oe_n & ~foe_d;
  wire ret_ack  = ret_oe_n & ~roe_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_q <= '0; ret_q <= '0; par_q <= 1'b0;
      fwd_flag <= 1'b0; ret_flag <= 1'b0;
      fstb_d <= 1'b0; rstb_d <= 1'b0; foe_d <= 1'b1; roe_d <= 1'b1;
    end else begin
      fstb_d <= fwd_stb; rstb_d <= ret_stb;
      foe_d  <= fwd_oe_n; roe_d <= ret_oe_n;
      if (fwd_load) fwd_q <= a_in;
      if (ret_load) begin
        ret_q <= b_in;
        par_q <= par_in;
      end
      if (fwd_load)     fwd_flag <= 1'b1;
      else if (fwd_ack) fwd_flag <= 1'b0;
      if (ret_load)     ret_flag <= 1'b1;
      else if (ret_ack) ret_flag <= 1'b0;
    end
  end

  assign b_out   = fwd_q;
  assign b_oe    = ~fwd_oe_n;
  assign par_out = ~^fwd_q;
  assign a_out   = ret_q;
  assign a_oe    = ~ret_oe_n;
  assign err_n   = ret_oe_n | (^{ret_q, par_q});

  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    (fwd_stb && !$past(fwd_stb) && !fwd_ld_n) |=> (b_out == $past(a_in)));
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !(fwd_stb && !fstb_d && !fwd_ld_n) |=> $stable(b_out));
  a_r4_set: assert property (@(posedge clk) disable iff (rst)
    (ret_stb && !rstb_d && !ret_ld_n) |=> ret_flag);
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (fwd_oe_n && !foe_d && !(fwd_stb && !fstb_d && !fwd_ld_n)) |=> !fwd_flag);
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    ret_oe_n |-> err_n);
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!fwd_flag && !ret_flag && b_out == '0 && a_out == '0));

endmodule

// File: tb/regxcvr_parity_test.sv
module regxcvr_parity_test;
  localparam int W = 8;
  logic clk = 0, rst = 1;
  logic [W-1:0] a_in = 0, b_in = 0;
  logic fwd_stb = 0, fwd_ld_n = 1, fwd_oe_n = 1;
  logic par_in = 0, ret_stb = 0, ret_ld_n = 1, ret_oe_n = 1;
  logic [W-1:0] b_out, a_out;
  logic b_oe, par_out, fwd_flag, a_oe, ret_flag, err_n;
  int errs = 0, checks = 0;
  logic [W-1:0] m_f = 0, m_r = 0;
  logic m_p = 0, m_ff = 0, m_rf = 0;

  always #5 clk = ~clk;

  regxcvr_parity #(.W(W)) uut (.*);

  function automatic logic gen_par(logic [W-1:0] v); return ~^v; endfunction
  function automatic logic exp_err(logic [W-1:0] v, logic p, logic oe);
    return oe ? 1'b1 : ((^v) ^ p);
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R1", b_out, m_f);
    chk("R3", a_out, m_r);
    chk("R8", par_out, gen_par(m_f));
    chk("R9", err_n, exp_err(m_r, m_p, ret_oe_n));
    chk("R7", {b_oe, a_oe}, {~fwd_oe_n, ~ret_oe_n});
    chk("R4/R5 fwd", fwd_flag, m_ff);
    chk("R4/R5 ret", ret_flag, m_rf);
  endtask

  task automatic step(logic fs, logic fl, logic fo, logic [W-1:0] a,
                      logic rs, logic rl, logic ro, logic [W-1:0] b, logic p);
    logic fload, rload;
    fload = fs & ~fwd_stb & ~fl;
    rload = rs & ~ret_stb & ~rl;
    if (fload) begin m_f = a; m_ff = 1; end
    else if (fo & ~fwd_oe_n) m_ff = 0;
    if (rload) begin m_r = b; m_p = p; m_rf = 1; end
    else if (ro & ~ret_oe_n) m_rf = 0;
    fwd_stb = fs; fwd_ld_n = fl; fwd_oe_n = fo; a_in = a;
    ret_stb = rs; ret_ld_n = rl; ret_oe_n = ro; b_in = b; par_in = p;
    @(posedge clk); #2;
    check_all();
  endtask

  initial begin
    #200000;
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    repeat (2) @(posedge clk);
    #2;
    chk("R10 flags", {fwd_flag, ret_flag}, 2'b00);
    chk("R10 data", {b_out, a_out}, 0);
    rst = 0;
    step(0,1,1,0, 0,1,1,0,0);
    // R2: strobe with enable high is ignored
    step(1,1,1,8'h5A, 1,1,1,8'hC3,1);
    step(0,1,1,0, 0,1,1,0,0);
    // R1/R3 loads, all-ones and all-zero data
    step(1,0,1,8'hFF, 1,0,1,8'h00,1);
    step(0,1,0,0, 0,1,0,0,0);
    step(0,1,1,0, 0,1,1,0,0);  // R5 clear
    step(1,0,1,8'h00, 1,0,1,8'hFF,0);
    step(0,1,0,0, 0,1,0,0,0);
    // R6: load coincides with clear edge
    step(1,0,1,8'h81, 1,0,1,8'h07,0);
    chk("R6 fwd", fwd_flag, 1'b1);
    chk("R6 ret", ret_flag, 1'b1);
    for (int i = 0; i < 400; i++)
      step($urandom%2, $urandom%2, $urandom%2, W'($urandom),
           $urandom%2, $urandom%2, $urandom%2, W'($urandom), $urandom%2);
    // R10: reset in mid-run
    rst = 1; @(posedge clk); #2; rst = 0;
    m_f = 0; m_r = 0; m_p = 0; m_ff = 0; m_rf = 0;
    chk("R10 after", {fwd_flag, ret_flag, b_out, a_out}, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule